// File: doc/BRIEF.md
# Super I/O Configuration Port Controller

This block guards the configuration space of a multi-function I/O chip. It sits behind a window of two adjacent I/O addresses. The lower address is an index port and the upper one is a data port. Software cannot reach the space until it writes the unlock byte 0x55 to the index port twice in a row. After that, any other byte written to the index port selects one of sixteen 8-bit configuration registers, and the data port reads or writes the selected register. Writing 0xAA to the index port closes the space again.

The whole register file is driven out in parallel to downstream logic. A one-cycle change strobe, with the XOR of the old and new contents, goes out with every register write, so that consumers react only to the bits that moved. The data-port address is also used by the floppy controller. For that reason the block drives a release signal that tells the floppy controller to stop answering on that address for as long as the configuration space is open. The reset contents are fixed per chip, and one register carries a chip identifier set by a parameter.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the registers hold index 0 = 0x3A, 1 = 0x9F, 2 = 0xDC, 3 = 0x78, 6 = 0xFF, 13 = the CHIP_ID parameter (default 0x65), 14 = 0x01, and every other index holds 0x00. The space is closed, and the key history and index are cleared.
- R2: The space opens only when the two most recent bytes written to the index port (address 0x3F0) while closed are both 0x55. A different byte between two 0x55 writes restarts the sequence.
- R3: While the space is open, an index-port write of 0xAA closes it. Any other index-port byte, including 0x55, becomes the current index. Writes to addresses outside the window change neither the mode nor the index.
- R4: While the space is open, a data-port write (address 0x3F1) stores the byte into the indexed register when the index is below 16. A write with an index of 16 or more changes no register.
- R5: A data-port read while the space is open and the index is below 16 returns the indexed register. Every other read returns 0xFF: while closed, at the index port, with an index of 16 or more, or with the read strobe low.
- R6: While the space is closed, data-port writes change no register.
- R7: The floppy release output goes high on the clock edge that captures the second 0x55, and low on the edge that captures the 0xAA exit.
- R8: In the cycle after an accepted register write, exactly one strobe bit (bit n for index n) is high, and the change mask equals the old value XOR the new value. In all other cycles the strobe and the mask are zero.
- R9: After an exit, the history holds 0x55 then 0xAA, so a single 0x55 does not reopen the space. Two more are needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| io_addr | input | 16 | I/O address of the current access |
| io_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| io_rd | input | 1 | Read strobe; read data is combinational |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, 0xFF when not selected |
| cfg_active | output | 1 | Configuration space is open |
| fdc_port_release | output | 1 | Tells the floppy controller to give up the data-port address |
| cfg_regs | output | 128 | All registers, index n at bits 8n+7..8n |
| cfg_chg_stb | output | 16 | One-cycle write strobe per register |
| cfg_chg_mask | output | 8 | Bits changed by the strobed write |

## Verification
The hardest states to reach from the ports are the key-history corners. These are the restart after an interrupting byte, the case where a single 0x55 fails to reopen right after an exit, and the case where 0x55 written while open becomes an out-of-range index instead of a key. The stimulus builds each of these with exact sequences of index-port writes. A behavioural model, kept as a two-entry byte history, is compared with the mode, the release output, every register, the strobe and the read data on every clock. Out-of-range writes are checked by reading back all sixteen registers and confirming that no strobe fired.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  localparam logic [7:0] KEY_UNLOCK = 8'h55;
  localparam logic [7:0] KEY_EXIT   = 8'hAA;

  // Power-on contents of each configuration register.
  function automatic logic [7:0] cfg_reset_value(input int unsigned idx,
                                                 input logic [7:0] chip_id);
    logic [7:0] v;
    case (idx)
      0:       v = 8'h3A;
      1:       v = 8'h9F;
      2:       v = 8'hDC;
      3:       v = 8'h78;
      6:       v = 8'hFF;
      13:      v = chip_id;
      14:      v = 8'h01;
      default: v = 8'h00;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/sio_cfg_rst_sync.sv
module sio_cfg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/sio_cfg_key_ctl.sv
module sio_cfg_key_ctl #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          key_wr_en,
  input  logic [DW-1:0] key_wdata,
  output logic          cfg_open,
  output logic          fdc_release,
  output logic [DW-1:0] cfg_index
);
  import sio_cfg_pkg::*;

  // hist_q[1] is the newest index-port byte, hist_q[0] the one before it
  logic [DW-1:0] hist_q [2];
  logic [DW-1:0] hist_d [2];
  logic [DW-1:0] idx_q, idx_d;
  logic          rel_q, rel_d;
  logic          open_now;

  assign open_now = (hist_q[0] == DW'(KEY_UNLOCK)) && (hist_q[1] == DW'(KEY_UNLOCK));

  always_comb begin
    hist_d[0] = hist_q[0];
    hist_d[1] = hist_q[1];
    idx_d     = idx_q;
    rel_d     = rel_q;
    if (key_wr_en) begin
      if (open_now) begin
        if (key_wdata == DW'(KEY_EXIT)) begin
          hist_d[0] = hist_q[1];
          hist_d[1] = key_wdata;
          rel_d     = 1'b0;
        end else begin
          idx_d = key_wdata;
        end
      end else begin
        hist_d[0] = hist_q[1];
        hist_d[1] = key_wdata;
        if ((key_wdata == DW'(KEY_UNLOCK)) && (hist_q[1] == DW'(KEY_UNLOCK)))
          rel_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q[0] <= '0;
      hist_q[1] <= '0;
      idx_q     <= '0;
      rel_q     <= 1'b0;
    end else if (key_wr_en) begin
      hist_q[0] <= hist_d[0];
      hist_q[1] <= hist_d[1];
      idx_q     <= idx_d;
      rel_q     <= rel_d;
    end
  end

  assign cfg_open    = open_now;
  assign fdc_release = rel_q;
  assign cfg_index   = idx_q;
endmodule

// File: rtl/sio_cfg_regfile.sv
module sio_cfg_regfile #(
  parameter int unsigned NREG    = 16,
  parameter int unsigned DW      = 8,
  parameter logic [7:0]  CHIP_ID = 8'h65,
  localparam int unsigned IDXW   = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDXW-1:0]  wr_idx,
  input  logic [DW-1:0]    wdata,
  input  logic [IDXW-1:0]  rd_idx,
  output logic [DW-1:0]    rd_data,
  output logic [NREG*DW-1:0] regs_flat,
  output logic [NREG-1:0]  chg_stb,
  output logic [DW-1:0]    chg_mask
);
  import sio_cfg_pkg::*;

  logic [DW-1:0]   reg_q [NREG];
  logic [NREG-1:0] wr_sel;
  logic [NREG-1:0] stb_d;
  logic [DW-1:0]   mask_d;
  logic [DW-1:0]   old_val;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    assign wr_sel[g] = wr_en && (wr_idx == IDXW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         reg_q[g] <= DW'(cfg_reset_value(g, CHIP_ID));
      else if (wr_sel[g]) reg_q[g] <= wdata;
    end

    assign regs_flat[g*DW +: DW] = reg_q[g];
  end

  assign old_val = reg_q[wr_idx];
  assign rd_data = reg_q[rd_idx];

  always_comb begin
    stb_d  = wr_sel;
    mask_d = wr_en ? (old_val ^ wdata) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chg_stb  <= '0;
      chg_mask <= '0;
    end else begin
      chg_stb  <= stb_d;
      chg_mask <= mask_d;
    end
  end
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port #(
  parameter int unsigned AW         = 16,
  parameter int unsigned DW         = 8,
  parameter int unsigned NREG       = 16,
  parameter logic [AW-1:0] INDEX_ADDR = 16'h03F0,
  parameter logic [7:0]  CHIP_ID    = 8'h65,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      io_addr,
  input  logic               io_wr,
  input  logic               io_rd,
  input  logic [DW-1:0]      io_wdata,
  output logic [DW-1:0]      io_rdata,
  output logic               cfg_active,
  output logic               fdc_port_release,
  output logic [NREG*DW-1:0] cfg_regs,
  output logic [NREG-1:0]    cfg_chg_stb,
  output logic [DW-1:0]      cfg_chg_mask
);
  localparam int unsigned IDXW = $clog2(NREG);
  localparam logic [AW-1:0] DATA_ADDR = INDEX_ADDR + AW'(1);

  logic          rst_n_int;
  logic          idx_hit, dat_hit;
  logic          key_wr_en;
  logic          reg_wr_en;
  logic          idx_in_range;
  logic [DW-1:0] cur_index;
  logic [DW-1:0] rd_data;

  sio_cfg_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  assign idx_hit      = (io_addr == INDEX_ADDR);
  assign dat_hit      = (io_addr == DATA_ADDR);
  assign key_wr_en    = io_wr && idx_hit;
  assign idx_in_range = (int'(cur_index) < int'(NREG));
  assign reg_wr_en    = io_wr && dat_hit && cfg_active && idx_in_range;

  sio_cfg_key_ctl #(.DW(DW)) u_key (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .key_wr_en   (key_wr_en),
    .key_wdata   (io_wdata),
    .cfg_open    (cfg_active),
    .fdc_release (fdc_port_release),
    .cfg_index   (cur_index)
  );

  sio_cfg_regfile #(.NREG(NREG), .DW(DW), .CHIP_ID(CHIP_ID)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .wr_en     (reg_wr_en),
    .wr_idx    (cur_index[IDXW-1:0]),
    .wdata     (io_wdata),
    .rd_idx    (cur_index[IDXW-1:0]),
    .rd_data   (rd_data),
    .regs_flat (cfg_regs),
    .chg_stb   (cfg_chg_stb),
    .chg_mask  (cfg_chg_mask)
  );

  always_comb begin
    if (io_rd && dat_hit && cfg_active && idx_in_range) io_rdata = rd_data;
    else                                                 io_rdata = '1;
  end
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
  parameter int unsigned AW   = 16,
  parameter int unsigned DW   = 8,
  parameter int unsigned NREG = 16,
  parameter logic [AW-1:0] INDEX_ADDR = 16'h03F0
) (
  input logic               clk,
  input logic               rst_n,
  input logic [AW-1:0]      io_addr,
  input logic               io_wr,
  input logic               io_rd,
  input logic [DW-1:0]      io_wdata,
  input logic [DW-1:0]      io_rdata,
  input logic               cfg_active,
  input logic               fdc_port_release,
  input logic [NREG*DW-1:0] cfg_regs,
  input logic [NREG-1:0]    cfg_chg_stb,
  input logic [DW-1:0]      cfg_chg_mask
);
  localparam logic [AW-1:0] DATA_ADDR = INDEX_ADDR + AW'(1);

  // R2: opening only follows a 0x55 written at the index port
  assert_open_by_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_active) |-> $past(io_wr && io_addr == INDEX_ADDR && io_wdata == 8'h55));

  // R3: exit key closes the space
  assert_exit_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_active && io_wr && io_addr == INDEX_ADDR && io_wdata == 8'hAA) |=> !cfg_active);

  // R5: closed space reads as all ones
  assert_closed_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_active && io_rd) |-> io_rdata == 8'hFF);

  // R6: closed data-port writes leave the registers alone
  assert_locked_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_active && io_wr && io_addr == DATA_ADDR) |=> $stable(cfg_regs));

  // R7: release follows the mode
  assert_release_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fdc_port_release == cfg_active);

  // R8: at most one strobe, only after an open data-port write
  assert_stb_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cfg_chg_stb));

  assert_stb_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|cfg_chg_stb) |-> $past(cfg_active && io_wr && io_addr == DATA_ADDR));

  assert_mask_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_chg_stb == '0) |-> (cfg_chg_mask == '0));
endmodule

bind sio_cfg_port sio_cfg_port_chk #(
  .AW(AW), .DW(DW), .NREG(NREG), .INDEX_ADDR(INDEX_ADDR)
) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .io_addr          (io_addr),
  .io_wr            (io_wr),
  .io_rd            (io_rd),
  .io_wdata         (io_wdata),
  .io_rdata         (io_rdata),
  .cfg_active       (cfg_active),
  .fdc_port_release (fdc_port_release),
  .cfg_regs         (cfg_regs),
  .cfg_chg_stb      (cfg_chg_stb),
  .cfg_chg_mask     (cfg_chg_mask)
);

// File: tb/sio_cfg_port_test.sv
module sio_cfg_port_test;
  localparam logic [15:0] IDX = 16'h03F0;
  localparam logic [15:0] DAT = 16'h03F1;
  localparam logic [7:0]  CHIP = 8'h65;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [15:0]  io_addr = '0;
  logic         io_wr = 1'b0;
  logic         io_rd = 1'b0;
  logic [7:0]   io_wdata = '0;
  logic [7:0]   io_rdata;
  logic         cfg_active;
  logic         fdc_port_release;
  logic [127:0] cfg_regs;
  logic [15:0]  cfg_chg_stb;
  logic [7:0]   cfg_chg_mask;

  int n_checks = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  sio_cfg_port #(.CHIP_ID(CHIP)) uut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_active(cfg_active),
    .fdc_port_release(fdc_port_release), .cfg_regs(cfg_regs),
    .cfg_chg_stb(cfg_chg_stb), .cfg_chg_mask(cfg_chg_mask)
  );

  // ---------------- reference model ----------------
  int   m_prev, m_last, m_idx;
  bit   m_rel;
  byte unsigned m_regs [16];
  logic [15:0] m_stb;
  logic [7:0]  m_mask;

  function automatic byte unsigned rv(int i);
    case (i)
      0: return 8'h3A; 1: return 8'h9F; 2: return 8'hDC; 3: return 8'h78;
      6: return 8'hFF; 13: return CHIP; 14: return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  function automatic bit m_open();
    return (m_prev == 'h55) && (m_last == 'h55);
  endfunction

  function automatic logic [7:0] m_rdata();
    if (io_rd && io_addr == DAT && m_open() && m_idx < 16) return m_regs[m_idx];
    return 8'hFF;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prev = 0; m_last = 0; m_idx = 0; m_rel = 0;
      m_stb = '0; m_mask = '0;
      for (int i = 0; i < 16; i++) m_regs[i] = rv(i);
    end else begin
      bit opn;
      opn = m_open();
      m_stb = '0; m_mask = '0;
      if (io_wr && io_addr == IDX) begin
        if (opn && io_wdata != 8'hAA) m_idx = int'(io_wdata);
        else begin
          if (!opn && io_wdata == 8'h55 && m_last == 'h55) m_rel = 1;
          if (opn) m_rel = 0;
          m_prev = m_last; m_last = int'(io_wdata);
        end
      end else if (io_wr && io_addr == DAT && opn && m_idx < 16) begin
        m_stb[m_idx] = 1'b1;
        m_mask = m_regs[m_idx] ^ io_wdata;
        m_regs[m_idx] = io_wdata;
      end
    end
  end

  task automatic check(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    logic [127:0] exp_regs;
    for (int i = 0; i < 16; i++) exp_regs[i*8 +: 8] = m_regs[i];
    check(cfg_regs == exp_regs, "R4 register file", cfg_regs, exp_regs);
    check(cfg_active == m_open(), "R2 mode", 128'(cfg_active), 128'(m_open()));
    check(fdc_port_release == m_rel, "R7 release", 128'(fdc_port_release), 128'(m_rel));
    check(cfg_chg_stb == m_stb && cfg_chg_mask == m_mask, "R8 strobe/mask",
          {cfg_chg_stb, cfg_chg_mask}, {m_stb, m_mask});
    check(io_rdata == m_rdata(), "R5 read data", 128'(io_rdata), 128'(m_rdata()));
  end

  // ---------------- stimulus ----------------
  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(posedge clk); #2;
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(posedge clk); #2;
    io_wr = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, output logic [7:0] d);
    @(posedge clk); #2;
    io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata;
    @(posedge clk); #2;
    io_rd = 1'b0;
  endtask

  task automatic do_reset();
    @(posedge clk); #2 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    #500000;
    n_fail++; n_checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(posedge clk);
    #3;
    // R1: reset contents while reset is held
    for (int i = 0; i < 16; i++)
      check(cfg_regs[i*8 +: 8] == rv(i), "R1 reset value", cfg_regs[i*8 +: 8], rv(i));
    check(!cfg_active && !fdc_port_release, "R1 closed after reset",
          {cfg_active, fdc_port_release}, 0);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R5 / R6: closed
    rd(DAT, d); check(d == 8'hFF, "R5 closed read", d, 8'hFF);
    wr(DAT, 8'h11);
    check(cfg_regs[7:0] == 8'h3A, "R6 closed write ignored", cfg_regs[7:0], 8'h3A);
    check(cfg_chg_stb == '0, "R6 no strobe while closed", cfg_chg_stb, 0);

    // R2: interrupted key
    wr(IDX, 8'h55); wr(IDX, 8'h12); wr(IDX, 8'h55);
    check(!cfg_active, "R2 interrupted key stays closed", cfg_active, 0);
    wr(16'h02F8, 8'h55);
    check(!cfg_active, "R3 other address no key effect", cfg_active, 0);
    wr(IDX, 8'h55);
    check(cfg_active, "R2 opened by 55 55", cfg_active, 1);
    check(fdc_port_release, "R7 release high when open", fdc_port_release, 1);

    // R5: chip id readback
    wr(IDX, 8'h0D); rd(DAT, d);
    check(d == CHIP, "R5 chip id read", d, CHIP);
    rd(IDX, d); check(d == 8'hFF, "R5 index-port read", d, 8'hFF);

    // R8: strobe after write
    wr(IDX, 8'h02); wr(DAT, 8'hD8);
    check(cfg_chg_stb == 16'h0004 && cfg_chg_mask == 8'h04, "R8 strobe idx2",
          {cfg_chg_stb, cfg_chg_mask}, {16'h0004, 8'h04});
    rd(DAT, d); check(d == 8'hD8, "R4 write stored", d, 8'hD8);

    // R4: out-of-range index
    wr(IDX, 8'h20); wr(DAT, 8'h77);
    check(cfg_chg_stb == '0, "R4 out-of-range no strobe", cfg_chg_stb, 0);
    rd(DAT, d); check(d == 8'hFF, "R5 out-of-range read", d, 8'hFF);
    for (int i = 0; i < 16; i++) begin
      wr(IDX, 8'(i)); rd(DAT, d);
      check(d != 8'h77, "R4 no register took out-of-range data", d, 8'h77);
    end

    // walk writes over every register
    for (int i = 0; i < 16; i++) begin
      wr(IDX, 8'(i)); wr(DAT, 8'((i * 37) ^ 8'h5A));
      check(cfg_chg_stb == (16'h1 << i), "R8 strobe position", cfg_chg_stb, 16'h1 << i);
    end

    // R3: 0x55 while open is an index, not a key
    wr(IDX, 8'h55);
    check(cfg_active, "R3 55 while open keeps mode", cfg_active, 1);
    rd(DAT, d); check(d == 8'hFF, "R3 index 0x55 out of range", d, 8'hFF);
    wr(16'h03F8, 8'hAA);
    check(cfg_active, "R3 exit key at wrong address ignored", cfg_active, 1);
    wr(IDX, 8'hAA);
    check(!cfg_active, "R3 exit key closes", cfg_active, 0);
    check(!fdc_port_release, "R7 release low after exit", fdc_port_release, 0);

    // R9: single 55 after exit
    wr(IDX, 8'h55);
    check(!cfg_active, "R9 single 55 after exit stays closed", cfg_active, 0);
    wr(IDX, 8'h55);
    check(cfg_active, "R9 second 55 reopens", cfg_active, 1);
    wr(IDX, 8'h02); rd(DAT, d);
    check(d == 8'(74 ^ 8'h5A), "R4 value kept across close", d, 8'(74 ^ 8'h5A));

    // R1: reset mid-run
    do_reset();
    check(!cfg_active, "R1 closed after second reset", cfg_active, 0);
    check(cfg_regs[23:16] == 8'hDC, "R1 reg2 restored", cfg_regs[23:16], 8'hDC);
    wr(IDX, 8'h55);
    check(!cfg_active, "R1 key history cleared", cfg_active, 0);

    repeat (3) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule